// File: doc/BRIEF.md
# Repeating Block Copy and Compare Engine

This block performs byte-wide memory block operations on behalf of a processor core. It holds a source pointer, a destination pointer and a byte counter, all 16 bits wide, plus an 8-bit accumulator. A second, alternate bank holds another copy of the source pointer, destination pointer and counter. Software-visible work is requested with a two-bit command code and a one-cycle start pulse. The engine reaches memory through a simple byte port. Read data comes back in the cycle after a read strobe and is held until the next read.

Four commands exist. Code 0 loads the primary bank and the accumulator from the load inputs. Code 1 copies bytes downward and repeats until the counter reaches zero. Code 2 compares the accumulator with one byte and steps the source pointer upward. Code 3 exchanges the primary bank with the alternate bank. A finished command is reported by a single-cycle done pulse. The state machine has six states. ST_IDLE waits for start. ST_MV_RD reads a byte and then goes to ST_MV_WR. ST_MV_WR writes the byte, then goes back to ST_MV_RD, or goes to ST_FIN after the last byte. ST_CP_RD reads a byte and then goes to ST_CP_EV. ST_CP_EV updates the flags and then goes to ST_FIN. ST_FIN raises done and then returns to ST_IDLE. From ST_IDLE, a start with the load or exchange command goes directly to ST_FIN.

Top module: `blkmv_engine`

## Requirements
- R1: After reset, all pointers, the counter, the accumulator and every flag are zero. The outputs done, busy, mem_rd and mem_wr are low.
- R2: Start with command code 0 copies ld_src, ld_dst, ld_cnt and ld_acc into the primary source pointer, destination pointer, counter and accumulator. done is high in the cycle after the start.
- R3: Command code 1 runs one iteration per two cycles. In the first cycle mem_rd is high with mem_addr at the source pointer. In the second cycle mem_wr is high with mem_addr at the destination pointer and mem_wdata equal to the byte just read.
- R4: Each copy iteration decrements the source pointer, destination pointer and counter by one, clears flag_n, and sets flag_pv when the new counter is not zero. Iterations repeat until the counter reaches zero. done comes in the cycle after the final write.
- R5: A copy started with the counter at zero performs 65536 iterations, because the counter wraps, and ends with both pointers back at their start values.
- R6: Command code 2 reads the byte at the source pointer once. It sets flag_z when the accumulator equals that byte and sets flag_s to bit 7 of (accumulator minus byte). It sets flag_n to 1 and sets flag_pv when the decremented counter is not zero. It increments the source pointer, decrements the counter, and leaves the accumulator and destination pointer unchanged.
- R7: Command code 3 exchanges the source pointer, destination pointer and counter with the alternate bank in one step, without changing the accumulator. done follows in the next cycle. A second exchange restores the first set of values.
- R8: A start pulse is ignored while busy is high, including the cycle in which done is high.
- R9: mem_rd and mem_wr are never high together, and the load and exchange commands make no memory access.
- R10: done is high for exactly one cycle per accepted command and is followed by an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run cmd |
| cmd | input | 2 | 0 load, 1 copy down repeat, 2 compare step up, 3 bank exchange |
| ld_src | input | 16 | Source pointer value for the load command |
| ld_dst | input | 16 | Destination pointer value for the load command |
| ld_cnt | input | 16 | Counter value for the load command |
| ld_acc | input | 8 | Accumulator value for the load command |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data is returned in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, held after the read cycle |
| src_ptr | output | 16 | Primary source pointer |
| dst_ptr | output | 16 | Primary destination pointer |
| count | output | 16 | Primary byte counter |
| acc | output | 8 | Accumulator |
| flag_s | output | 1 | Sign of the last compare |
| flag_z | output | 1 | Equal result of the last compare |
| flag_pv | output | 1 | Counter not zero after the last step |
| flag_n | output | 1 | Last step was a compare |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: the completion of one command and the start of the next. The bench forces this in two ways. It raises start with a different command in the middle of a multi-iteration copy, and it raises start in the very cycle where done is high. In both cases it expects the copy's final pointers, counter and memory image to match the copy alone. It also expects no second done pulse and no change to the registers in the cycles that follow.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD    = 2'd0,
        OP_MOVE_DN = 2'd1,
        OP_CMP_UP  = 2'd2,
        OP_SWAP    = 2'd3
    } blk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MV_RD,
        ST_MV_WR,
        ST_CP_RD,
        ST_CP_EV,
        ST_FIN
    } blk_state_e;

    localparam int NUM_BANK_REGS = 3;
    localparam int IDX_SRC = 0;
    localparam int IDX_DST = 1;
    localparam int IDX_CNT = 2;

endpackage

// File: rtl/blkmv_fsm.sv
module blkmv_fsm
    import blkmv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic [1:0] cmd,
    input  logic cnt_is_one,
    output logic rd_strobe,
    output logic wr_strobe,
    output logic addr_dst,
    output logic load_en,
    output logic swap_en,
    output logic mv_step,
    output logic cmp_step,
    output logic busy,
    output logic done
);

    blk_state_e state_q, state_d;
    blk_op_e    op;

    assign op = blk_op_e'(cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (op)
                        OP_LOAD:    state_d = ST_FIN;
                        OP_MOVE_DN: state_d = ST_MV_RD;
                        OP_CMP_UP:  state_d = ST_CP_RD;
                        OP_SWAP:    state_d = ST_FIN;
                    endcase
                end
            end
            ST_MV_RD: state_d = ST_MV_WR;
            ST_MV_WR: state_d = cnt_is_one ? ST_FIN : ST_MV_RD;
            ST_CP_RD: state_d = ST_CP_EV;
            ST_CP_EV: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        addr_dst  = 1'b0;
        load_en   = 1'b0;
        swap_en   = 1'b0;
        mv_step   = 1'b0;
        cmp_step  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_en = start && (op == OP_LOAD);
                swap_en = start && (op == OP_SWAP);
            end
            ST_MV_RD: rd_strobe = 1'b1;
            ST_MV_WR: begin
                wr_strobe = 1'b1;
                addr_dst  = 1'b1;
                mv_step   = 1'b1;
            end
            ST_CP_RD: rd_strobe = 1'b1;
            ST_CP_EV: cmp_step  = 1'b1;
            ST_FIN:   done      = 1'b1;
            default:  busy      = 1'b0;
        endcase
    end

endmodule

// File: rtl/blkmv_bank.sv
module blkmv_bank
    import blkmv_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic swap_en,
    input  logic mv_step,
    input  logic cmp_step,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [AW-1:0] ld_cnt,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [AW-1:0] cnt
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] prim_q [NUM_BANK_REGS];
    logic [AW-1:0] alt_q  [NUM_BANK_REGS];
    logic [AW-1:0] ld_val [NUM_BANK_REGS];

    assign ld_val[IDX_SRC] = ld_src;
    assign ld_val[IDX_DST] = ld_dst;
    assign ld_val[IDX_CNT] = ld_cnt;

    for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_reg
        logic inc_en, dec_en;
        if (i == IDX_SRC) begin : g_src
            assign inc_en = cmp_step;
            assign dec_en = mv_step;
        end else if (i == IDX_DST) begin : g_dst
            assign inc_en = 1'b0;
            assign dec_en = mv_step;
        end else begin : g_cnt
            assign inc_en = 1'b0;
            assign dec_en = mv_step | cmp_step;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prim_q[i] <= '0;
                alt_q[i]  <= '0;
            end else if (swap_en) begin
                prim_q[i] <= alt_q[i];
                alt_q[i]  <= prim_q[i];
            end else if (load_en) begin
                prim_q[i] <= ld_val[i];
            end else if (inc_en) begin
                prim_q[i] <= prim_q[i] + ONE;
            end else if (dec_en) begin
                prim_q[i] <= prim_q[i] - ONE;
            end
        end
    end

    assign src = prim_q[IDX_SRC];
    assign dst = prim_q[IDX_DST];
    assign cnt = prim_q[IDX_CNT];

endmodule

// File: rtl/blkmv_acc_flags.sv
module blkmv_acc_flags #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic mv_step,
    input  logic cmp_step,
    input  logic [DW-1:0] ld_acc,
    input  logic [DW-1:0] rdata,
    input  logic [AW-1:0] cnt,
    output logic [DW-1:0] acc,
    output logic f_s,
    output logic f_z,
    output logic f_pv,
    output logic f_n
);

    localparam logic [AW-1:0] CNT_ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [DW-1:0] acc_q;
    logic [DW-1:0] diff;
    logic          pv_next;
    logic          s_q, z_q, pv_q, n_q;

    assign diff    = acc_q - rdata;
    assign pv_next = (cnt != CNT_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= ld_acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q  <= 1'b0;
            z_q  <= 1'b0;
            pv_q <= 1'b0;
            n_q  <= 1'b0;
        end else if (cmp_step) begin
            s_q  <= diff[DW-1];
            z_q  <= (diff == '0);
            pv_q <= pv_next;
            n_q  <= 1'b1;
        end else if (mv_step) begin
            pv_q <= pv_next;
            n_q  <= 1'b0;
        end
    end

    assign acc  = acc_q;
    assign f_s  = s_q;
    assign f_z  = z_q;
    assign f_pv = pv_q;
    assign f_n  = n_q;

endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cmd,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    input  logic [AW-1:0] ld_cnt,
    input  logic [DW-1:0] ld_acc,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic [AW-1:0] count,
    output logic [DW-1:0] acc,
    output logic          flag_s,
    output logic          flag_z,
    output logic          flag_pv,
    output logic          flag_n,
    output logic          busy,
    output logic          done
);

    localparam logic [AW-1:0] CNT_ONE = {{(AW-1){1'b0}}, 1'b1};

    logic rd_strobe, wr_strobe, addr_dst;
    logic load_en, swap_en, mv_step, cmp_step;
    logic [AW-1:0] src_w, dst_w, cnt_w;

    blkmv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd        (cmd),
        .cnt_is_one (cnt_w == CNT_ONE),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .addr_dst   (addr_dst),
        .load_en    (load_en),
        .swap_en    (swap_en),
        .mv_step    (mv_step),
        .cmp_step   (cmp_step),
        .busy       (busy),
        .done       (done)
    );

    blkmv_bank #(.AW(AW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .swap_en  (swap_en),
        .mv_step  (mv_step),
        .cmp_step (cmp_step),
        .ld_src   (ld_src),
        .ld_dst   (ld_dst),
        .ld_cnt   (ld_cnt),
        .src      (src_w),
        .dst      (dst_w),
        .cnt      (cnt_w)
    );

    blkmv_acc_flags #(.AW(AW), .DW(DW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .mv_step  (mv_step),
        .cmp_step (cmp_step),
        .ld_acc   (ld_acc),
        .rdata    (mem_rdata),
        .cnt      (cnt_w),
        .acc      (acc),
        .f_s      (flag_s),
        .f_z      (flag_z),
        .f_pv     (flag_pv),
        .f_n      (flag_n)
    );

    assign mem_addr  = addr_dst ? dst_w : src_w;
    assign mem_rd    = rd_strobe;
    assign mem_wr    = wr_strobe;
    assign mem_wdata = wr_strobe ? mem_rdata : '0;
    assign src_ptr   = src_w;
    assign dst_ptr   = dst_w;
    assign count     = cnt_w;

endmodule

// File: rtl/blkmv_checker.sv
module blkmv_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] count,
    input logic [DW-1:0] acc,
    input logic          busy,
    input logic          done
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (count == ($past(count) - ONE)));

    p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc));

    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind blkmv_engine blkmv_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .count  (count),
    .acc    (acc),
    .busy   (busy),
    .done   (done)
);

// File: tb/sim_blkmv_engine.sv
`timescale 1ns/1ps
module sim_blkmv_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [15:0] ld_src = '0, ld_dst = '0, ld_cnt = '0;
    logic [7:0]  ld_acc = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] src_ptr, dst_ptr, count;
    logic [7:0]  acc;
    logic        flag_s, flag_z, flag_pv, flag_n, busy, done;

    int checks = 0;
    int errors = 0;
    int wr_events = 0;
    int rd_events = 0;
    int cycles = 0;

    logic [7:0] mem [0:65535];

    always #4 clk = ~clk;

    blkmv_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_acc(ld_acc),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count), .acc(acc),
        .flag_s(flag_s), .flag_z(flag_z), .flag_pv(flag_pv), .flag_n(flag_n),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            rd_events <= rd_events + 1;
        end
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_events <= wr_events + 1;
        end
    end

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c);
        @(negedge clk);
        cmd   = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] n, input logic [7:0] a);
        ld_src = s; ld_dst = d; ld_cnt = n; ld_acc = a;
        issue(2'd0);
    endtask

    task automatic wait_done(input int limit, output int waited);
        waited = 0;
        while (!done && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic t_reset();
        chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R1", "pointers",
            {src_ptr, dst_ptr}, 0);
        chk(acc == 0 && !flag_s && !flag_z && !flag_pv && !flag_n, "R1", "acc/flags",
            {acc, flag_s, flag_z, flag_pv, flag_n}, 0);
        chk(!done && !busy && !mem_rd && !mem_wr, "R1", "controls",
            {done, busy, mem_rd, mem_wr}, 0);
    endtask

    task automatic t_load();
        int r0, w0;
        r0 = rd_events; w0 = wr_events;
        do_load(16'h1003, 16'h2003, 16'h0004, 8'h99);
        chk(done, "R2", "done one cycle after start", done, 1);
        chk(src_ptr == 16'h1003 && dst_ptr == 16'h2003, "R2", "pointers",
            {src_ptr, dst_ptr}, 32'h10032003);
        chk(count == 16'h0004 && acc == 8'h99, "R2", "count/acc",
            {count, acc}, {16'h0004, 8'h99});
        @(negedge clk);
        chk(!done, "R10", "done single cycle", done, 0);
        chk(rd_events == r0 && wr_events == w0, "R9", "load made no access",
            rd_events - r0 + wr_events - w0, 0);
    endtask

    task automatic t_move();
        int waited, w0;
        bit seen_rd, seen_wr, ok_seq;
        w0 = wr_events;
        seen_rd = 0; seen_wr = 0; ok_seq = 1;
        @(negedge clk);
        cmd = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_rd && !mem_wr && mem_addr == 16'h1003, "R3", "first read at source",
            {mem_rd, mem_wr, mem_addr}, {2'b10, 16'h1003});
        @(negedge clk);
        chk(mem_wr && !mem_rd && mem_addr == 16'h2003 && mem_wdata == pat(16'h1003),
            "R3", "first write to destination", {mem_addr, mem_wdata},
            {16'h2003, pat(16'h1003)});
        wait_done(50, waited);
        chk(done, "R4", "done after last write", done, 1);
        chk(wr_events - w0 == 4, "R4", "iterations", wr_events - w0, 4);
        chk(src_ptr == 16'h0FFF && dst_ptr == 16'h1FFF && count == 0, "R4",
            "final pointers", {src_ptr, dst_ptr}, 32'h0FFF1FFF);
        chk(!flag_pv && !flag_n, "R4", "pv/n cleared", {flag_pv, flag_n}, 0);
        for (int i = 0; i < 4; i++)
            chk(mem[16'h2000 + i] == pat(16'h1000 + i), "R3", "copied byte",
                mem[16'h2000 + i], pat(16'h1000 + i));
        chk(mem[16'h1FFF] == pat(16'h1FFF), "R4", "byte below block untouched",
            mem[16'h1FFF], pat(16'h1FFF));
        @(negedge clk);
    endtask

    task automatic t_move_pv();
        int waited;
        do_load(16'h4010, 16'h5010, 16'h0003, 8'h00);
        issue(2'd1);
        @(negedge clk);
        @(negedge clk);
        chk(flag_pv && count == 16'h0002, "R4", "pv set mid-run",
            {flag_pv, count}, {1'b1, 16'h0002});
        wait_done(50, waited);
        @(negedge clk);
    endtask

    task automatic t_compare();
        int waited;
        logic [7:0] b, d;
        b = mem[16'h3000];
        do_load(16'h3000, 16'h7777, 16'h0003, b);
        issue(2'd2);
        wait_done(20, waited);
        chk(flag_z && !flag_s && flag_n && flag_pv, "R6", "equal compare flags",
            {flag_s, flag_z, flag_pv, flag_n}, 4'b0111);
        chk(src_ptr == 16'h3001 && count == 16'h0002 && dst_ptr == 16'h7777 && acc == b,
            "R6", "equal compare regs", {src_ptr, count}, 32'h30010002);
        @(negedge clk);
        b = mem[16'h3001];
        do_load(16'h3001, 16'h7777, 16'h0001, 8'h05);
        issue(2'd2);
        wait_done(20, waited);
        d = 8'h05 - b;
        chk(flag_z == (d == 0) && flag_s == d[7] && flag_n && !flag_pv, "R6",
            "unequal compare flags", {flag_s, flag_z, flag_pv, flag_n},
            {d[7], d == 8'h00, 1'b0, 1'b1});
        chk(acc == 8'h05 && src_ptr == 16'h3002 && count == 0, "R6",
            "acc unchanged, last step", {acc, src_ptr, count}, {8'h05, 16'h3002, 16'h0000});
        @(negedge clk);
    endtask

    task automatic t_swap();
        int r0, w0;
        do_load(16'hAAAA, 16'hBBBB, 16'hCCCC, 8'h11);
        @(negedge clk);
        r0 = rd_events; w0 = wr_events;
        issue(2'd3);
        chk(done, "R7", "done after exchange", done, 1);
        @(negedge clk);
        do_load(16'h1111, 16'h2222, 16'h3333, 8'h11);
        @(negedge clk);
        issue(2'd3);
        chk(src_ptr == 16'hAAAA && dst_ptr == 16'hBBBB && count == 16'hCCCC,
            "R7", "first set back", {src_ptr, dst_ptr}, 32'hAAAABBBB);
        @(negedge clk);
        issue(2'd3);
        chk(src_ptr == 16'h1111 && dst_ptr == 16'h2222 && count == 16'h3333 && acc == 8'h11,
            "R7", "second set back, acc kept", {src_ptr, count}, 32'h11113333);
        chk(rd_events == r0 && wr_events == w0, "R9", "exchange made no access",
            rd_events - r0 + wr_events - w0, 0);
        @(negedge clk);
    endtask

    task automatic t_overlap();
        int waited, w0;
        logic [15:0] s0, d0, c0;
        do_load(16'h6001, 16'h6801, 16'h0002, 8'h00);
        @(negedge clk);
        w0 = wr_events;
        issue(2'd1);
        cmd = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(50, waited);
        chk(src_ptr == 16'h5FFF && dst_ptr == 16'h67FF && count == 0, "R8",
            "start during copy ignored", {src_ptr, dst_ptr}, 32'h5FFF67FF);
        chk(mem[16'h6800] == pat(16'h6000) && wr_events - w0 == 2, "R8",
            "copy result intact", mem[16'h6800], pat(16'h6000));
        s0 = src_ptr; d0 = dst_ptr; c0 = count;
        ld_src = 16'hDEAD; ld_dst = 16'hBEEF; ld_cnt = 16'h0F0F; ld_acc = 8'h77;
        cmd = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !busy, "R8", "start in done cycle not accepted", {done, busy}, 0);
        @(negedge clk);
        chk(src_ptr == s0 && dst_ptr == d0 && count == c0 && acc == 8'h00, "R8",
            "registers unchanged", {src_ptr, dst_ptr}, {s0, d0});
    endtask

    task automatic t_wrap();
        int waited, w0;
        do_load(16'hFFFF, 16'h7FFF, 16'h0000, 8'h00);
        @(negedge clk);
        w0 = wr_events;
        issue(2'd1);
        wait_done(140000, waited);
        chk(done, "R5", "wrapped copy finished", done, 1);
        chk(wr_events - w0 == 65536, "R5", "iterations", wr_events - w0, 65536);
        chk(src_ptr == 16'hFFFF && dst_ptr == 16'h7FFF && count == 0, "R5",
            "pointers back at start", {src_ptr, dst_ptr}, 32'hFFFF7FFF);
        @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 65536; a++) mem[a] = pat(a[15:0]);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_move();
        t_move_pv();
        t_compare();
        t_swap();
        t_overlap();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles >= 180000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<180000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule